// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block produces the drive waveforms for a passive liquid-crystal panel scanned at 1/8 duty with 1/4 bias. Eight common lines are selected one at a time. Up to `NSEG` segment lines (at least 8, at most 40, so up to 320 dots) carry the display data for whichever common is active. Each pin is given as a 3-bit bias-level code (0 to 4 for levels V0 to V4). External analog switches turn that code into a voltage.

A one-cycle `slow_tick` pulse, generated from the 32768 Hz clock domain, moves the scan on by one common slot. A dot store holds one byte per segment, with bit n belonging to common n. At each slot boundary the block copies the column for the next common into a snapshot register. A dot write therefore shows up at the next slot boundary and never part way through a slot.

A 3-bit control register holds three controls. The enable turns the driver on or off; when it is off, every pin sits at V0. The blank control forces the commons to their non-select levels, so no dot is lit. The type bit selects one of two polarity-inversion schemes. Both schemes keep the average voltage on every pixel at zero over two frames.

The scan controller has two states. In `ST_IDLE` the driver is not scanning. In `ST_SCAN` the commons are being cycled. The transitions are:
- START: from `ST_IDLE` to `ST_SCAN` on a tick while the enable is set.
- STEP: inside `ST_SCAN` on each tick; the slot moves on by one.
- WRAP: a STEP taken from slot 7; the slot returns to 0 and the frame parity toggles.
- STOP: from `ST_SCAN` to `ST_IDLE` in the cycle after the enable is cleared.

Top module: `lcd_mux_drv`

## Requirements
- R1: A write with `ctl_we` stores `ctl_wdata[2:0]` as the enable (bit 0), blank (bit 1) and type (bit 2) controls. From the next cycle `ctl_rdata` returns these three bits, and bits 7 to 3 read as zero. After reset all three bits are 0.
- R2: While the enable is 0, every common and segment code is 0 (V0). The scan starts again after each enable. On the first tick with the enable set, the driver selects common 0 in positive phase with frame parity 0.
- R3: While scanning, each tick advances the active common by one, in the order 0, 1, …, 7, 0. When not blanked, exactly one common carries a select level in each slot, and each common is selected exactly once per frame.
- R4: The 3-bit field of common i is `com_lvl[3i+2:3i]` and the field of segment s is `seg_lvl[3s+2:3s]`. Codes 0 to 4 mean V0 to V4. The selected common drives 4 in positive phase and 0 in negative phase. A non-selected common drives 1 in positive phase and 3 in negative phase.
- R5: A segment whose dot is on for the active common drives 0 in positive phase and 4 in negative phase. A segment whose dot is off drives 2 in both phases.
- R6: Type 0: the phase is negative when (slot bit 0) XOR (frame parity) is 1. The polarity therefore flips after every slot, and the whole pattern flips each frame.
- R7: Type 1: the phase equals the frame parity. It flips only when the scan wraps from common 7 to common 0.
- R8: With blank set while scanning, every common is at its non-select level (1 or 3, by phase). The segments keep following the display data.
- R9: Dot store byte `dot_addr` belongs to segment `dot_addr`, and bit n of that byte is the dot for common n. Writes to addresses at or above `NSEG` are ignored. A written byte affects the outputs only from the next tick that starts a slot.
- R10: With static data and either type, the sum of (common code − segment code) over the 16 slots of two consecutive frames is zero for every pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle slot-advance enable from the slow clock domain |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register readback |
| dot_we | input | 1 | Dot store write strobe |
| dot_addr | input | $clog2(NSEG) | Segment index of the byte written |
| dot_wdata | input | 8 | Dot byte, bit n for common n |
| com_lvl | output | 24 | Bias-level code per common, 3 bits each |
| seg_lvl | output | 3*NSEG | Bias-level code per segment, 3 bits each |

## Verification
A wrong slot count or a wrong frame parity changes a common or segment code in the same cycle it arises. The reference model compares every clock, so such a fault is reported within one slot. A stale or torn column snapshot changes the segment codes from the next tick onward. A polarity fault that leaves each single slot looking legal still breaks the two-frame pixel sum, and the DC check reports it at the end of that two-frame run.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
    localparam int NCOM  = 8;
    localparam int COM_W = 3;
    localparam int LVL_W = 3;

    typedef enum logic [2:0] {
        LV0 = 3'd0,
        LV1 = 3'd1,
        LV2 = 3'd2,
        LV3 = 3'd3,
        LV4 = 3'd4
    } lvl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_t;

    typedef struct packed {
        logic wtype;
        logic blank;
        logic en;
    } ctl_t;
endpackage

// File: rtl/lcd_ctl_reg.sv
module lcd_ctl_reg
    import lcd_drv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output logic [7:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ctl <= '0;
        else if (we) ctl <= wdata[2:0];
    end

    assign rdata = {5'b0, ctl};

    // R1: a write is visible on the readback in the next cycle
    a_r1_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata[2:0] == $past(wdata[2:0]));
endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_drv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    output logic             scanning,
    output logic [COM_W-1:0] slot,
    output logic             fpar,
    output logic             load,
    output logic [COM_W-1:0] load_row
);
    scan_st_t state, state_nx;
    logic [COM_W-1:0] slot_nx;
    logic fpar_nx;

    always_comb begin
        state_nx = state;
        slot_nx  = slot;
        fpar_nx  = fpar;
        unique case (state)
            ST_IDLE: begin
                if (en && tick) begin          // START
                    state_nx = ST_SCAN;
                    slot_nx  = '0;
                    fpar_nx  = 1'b0;
                end
            end
            ST_SCAN: begin
                if (!en) begin                 // STOP
                    state_nx = ST_IDLE;
                end else if (tick) begin       // STEP / WRAP
                    slot_nx = slot + COM_W'(1);
                    if (slot == COM_W'(NCOM - 1)) fpar_nx = ~fpar;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
            fpar  <= 1'b0;
        end else begin
            state <= state_nx;
            slot  <= slot_nx;
            fpar  <= fpar_nx;
        end
    end

    always_comb begin
        scanning = (state == ST_SCAN);
        load     = en && tick;
        load_row = (state == ST_SCAN) ? slot + COM_W'(1) : '0;
    end

    // R3: each tick in the scan moves the slot on by one
    a_r3_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && en && tick) |=> slot == $past(slot) + COM_W'(1));
    // R7: frame parity flips on the wrap from the last common
    a_r7_wrap_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && en && tick && slot == COM_W'(NCOM - 1)) |=> fpar != $past(fpar));
    // R2: scan restarts at common 0 with parity 0
    a_r2_start_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en && tick) |=> (slot == '0 && !fpar));
endmodule

// File: rtl/lcd_dot_ram.sv
module lcd_dot_ram
    import lcd_drv_pkg::*;
#(
    parameter int NSEG = 40,
    localparam int AW  = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    input  logic             load,
    input  logic [COM_W-1:0] row,
    output logic [NSEG-1:0]  dots
);
    logic [NCOM-1:0] mem [NSEG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSEG; s++) mem[s] <= '0;
        end else if (we && int'(addr) < NSEG) begin
            mem[addr] <= wdata[NCOM-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dots <= '0;
        end else if (load) begin
            for (int s = 0; s < NSEG; s++) dots[s] <= mem[s][row];
        end
    end

    // R9: the snapshot only changes at a slot-starting tick
    a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dots));
endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
    import lcd_drv_pkg::*;
#(
    parameter int NSEG = 40,
    localparam int AW  = $clog2(NSEG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  slow_tick,
    input  logic                  ctl_we,
    input  logic [7:0]            ctl_wdata,
    output logic [7:0]            ctl_rdata,
    input  logic                  dot_we,
    input  logic [AW-1:0]         dot_addr,
    input  logic [7:0]            dot_wdata,
    output logic [NCOM*LVL_W-1:0] com_lvl,
    output logic [NSEG*LVL_W-1:0] seg_lvl
);
    ctl_t ctl;
    logic scanning, fpar, load, phase, active;
    logic [COM_W-1:0] slot, load_row;
    logic [NSEG-1:0] dots;

    lcd_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .ctl(ctl), .rdata(ctl_rdata)
    );

    lcd_scan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick), .en(ctl.en),
        .scanning(scanning), .slot(slot), .fpar(fpar),
        .load(load), .load_row(load_row)
    );

    lcd_dot_ram #(.NSEG(NSEG)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(dot_we), .addr(dot_addr),
        .wdata(dot_wdata), .load(load), .row(load_row), .dots(dots)
    );

    assign active = scanning && ctl.en;
    // phase 0 = positive, 1 = negative
    assign phase  = ctl.wtype ? fpar : (fpar ^ slot[0]);

    logic [NCOM-1:0] com_is_sel;
    logic [NSEG-1:0] seg_legal;

    for (genvar i = 0; i < NCOM; i++) begin : g_com
        lvl_t l;
        always_comb begin
            if (!active)
                l = LV0;
            else if (slot == COM_W'(i) && !ctl.blank)
                l = phase ? LV0 : LV4;
            else
                l = phase ? LV3 : LV1;
        end
        assign com_lvl[i*LVL_W +: LVL_W] = l;
        assign com_is_sel[i] = (com_lvl[i*LVL_W +: LVL_W] == LV4) ||
                               (com_lvl[i*LVL_W +: LVL_W] == LV0);
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        lvl_t l;
        always_comb begin
            if (!active)      l = LV0;
            else if (dots[s]) l = phase ? LV4 : LV0;
            else              l = LV2;
        end
        assign seg_lvl[s*LVL_W +: LVL_W] = l;
        assign seg_legal[s] = (seg_lvl[s*LVL_W +: LVL_W] == LV0) ||
                              (seg_lvl[s*LVL_W +: LVL_W] == LV2) ||
                              (seg_lvl[s*LVL_W +: LVL_W] == LV4);
    end

    // R3: exactly one common at a select level per slot when not blanked
    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ctl.blank) |-> $countones(com_is_sel) == 1);
    // R8: blanking leaves no common at a select level
    a_r8_blank_nonselect: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ctl.blank) |-> com_is_sel == '0);
    // R5: segments only use V0, V2 or V4 while scanning
    a_r5_seg_legal: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> &seg_legal);
    // R2: a cleared enable grounds every pin
    a_r2_off_ground: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |-> (com_lvl == '0 && seg_lvl == '0));
endmodule

// File: tb/tb_lcd_mux_drv.sv
module tb_lcd_mux_drv;
    localparam int NSEG = 40;
    localparam int AW   = $clog2(NSEG);

    logic clk = 0, rst_n = 0, slow_tick = 0, ctl_we = 0, dot_we = 0;
    logic [7:0] ctl_wdata = 0, dot_wdata = 0, ctl_rdata;
    logic [AW-1:0] dot_addr = 0;
    logic [23:0] com_lvl;
    logic [NSEG*3-1:0] seg_lvl;

    int n_cmp = 0, n_bad = 0, cycles = 0;

    always #2 clk = ~clk;

    lcd_mux_drv #(.NSEG(NSEG)) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .dot_we(dot_we), .dot_addr(dot_addr), .dot_wdata(dot_wdata),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // behavioural reference model
    bit m_scan, m_fpar, m_en, m_blank, m_type;
    int m_slot;
    logic [7:0] m_ram [NSEG];
    bit m_dots [NSEG];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_scan = 0; m_fpar = 0; m_slot = 0;
            m_en = 0; m_blank = 0; m_type = 0;
            foreach (m_ram[s]) begin m_ram[s] = 0; m_dots[s] = 0; end
        end else begin
            if (m_scan && !m_en) m_scan = 0;
            else if (slow_tick && m_en) begin
                if (!m_scan) begin m_scan = 1; m_slot = 0; m_fpar = 0; end
                else if (m_slot == 7) begin m_slot = 0; m_fpar = !m_fpar; end
                else m_slot++;
                foreach (m_dots[s]) m_dots[s] = m_ram[s][m_slot];
            end
            if (dot_we && int'(dot_addr) < NSEG) m_ram[dot_addr] = dot_wdata;
            if (ctl_we) {m_type, m_blank, m_en} = ctl_wdata[2:0];
        end
    end

    function automatic bit m_phase();
        return m_type ? m_fpar : (m_fpar ^ m_slot[0]);
    endfunction

    function automatic int exp_com(int c);
        bit sel;
        if (!(m_scan && m_en)) return 0;
        sel = (c == m_slot) && !m_blank;
        if (!m_phase()) return sel ? 4 : 1;
        return sel ? 0 : 3;
    endfunction

    function automatic int exp_seg(int s);
        if (!(m_scan && m_en)) return 0;
        if (!m_dots[s]) return 2;
        return m_phase() ? 4 : 0;
    endfunction

    function automatic int com_at(int c); return int'(com_lvl[3*c +: 3]); endfunction
    function automatic int seg_at(int s); return int'(seg_lvl[3*s +: 3]); endfunction

    task automatic check(string req, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // per-clock comparison against the model (R1, R4, R5, R6, R7, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            int bc, bs;
            bc = 0; bs = 0;
            check("R1 ctl_rdata", int'(ctl_rdata), int'({5'b0, m_type, m_blank, m_en}));
            for (int c = 0; c < 8; c++) if (com_at(c) != exp_com(c)) begin
                check($sformatf("R4 R6 R7 R8 com%0d", c), com_at(c), exp_com(c)); bc++;
            end
            for (int s = 0; s < NSEG; s++) if (seg_at(s) != exp_seg(s)) begin
                check($sformatf("R5 R9 seg%0d", s), seg_at(s), exp_seg(s)); bs++;
            end
            if (bc == 0) n_cmp++;
            if (bs == 0) n_cmp++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr_ctl(logic [7:0] v);
        @(negedge clk); ctl_we = 1; ctl_wdata = v;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic wr_dot(int a, logic [7:0] d);
        @(negedge clk); dot_we = 1; dot_addr = AW'(a); dot_wdata = d;
        @(negedge clk); dot_we = 0;
    endtask

    task automatic tick_once();
        @(negedge clk); slow_tick = 1;
        @(negedge clk); slow_tick = 0;
    endtask

    // R10 and R3: two frames from a fresh start, DC sum and select count
    task automatic two_frame_run(logic [7:0] ctlv, string tag);
        int acc [NSEG][8];
        int nsel [8];
        int bad_dc, bad_sel;
        wr_ctl(8'h00);
        wr_ctl(ctlv);
        foreach (acc[s, c]) acc[s][c] = 0;
        foreach (nsel[c]) nsel[c] = 0;
        bad_dc = 0; bad_sel = 0;
        for (int k = 0; k < 16; k++) begin
            tick_once();
            for (int c = 0; c < 8; c++) begin
                if (com_at(c) == 4 || com_at(c) == 0) nsel[c]++;
                for (int s = 0; s < NSEG; s++) acc[s][c] += com_at(c) - seg_at(s);
            end
            if (k == 7 || k == 15) begin
                for (int c = 0; c < 8; c++) if (nsel[c] != 1) bad_sel++;
                foreach (nsel[c]) nsel[c] = 0;
            end
        end
        foreach (acc[s, c]) if (acc[s][c] != 0) bad_dc++;
        check({"R10 DC-sum nonzero pixels ", tag}, bad_dc, 0);
        check({"R3 select-once errors ", tag}, bad_sel, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset com", int'(com_lvl), 0);
        check("R2 reset seg", int'(|seg_lvl), 0);
        check("R1 reset rdata", int'(ctl_rdata), 0);
        rst_n = 1;

        // R9 load a pattern; out-of-range address ignored
        for (int s = 0; s < NSEG; s++) wr_dot(s, 8'((s * 37 + 5) ^ (s << 3)));
        wr_dot(NSEG, 8'hFF);
        wr_dot(63, 8'hFF);

        // R1 upper bits read as zero
        wr_ctl(8'hF8);
        check("R1 upper bits", int'(ctl_rdata), 0);

        // R2 ticks while disabled keep every pin at V0
        tick_once(); tick_once();
        check("R2 disabled com", int'(com_lvl), 0);
        check("R2 disabled seg", int'(|seg_lvl), 0);

        two_frame_run(8'h01, "typeA");
        two_frame_run(8'h05, "typeB");

        // R8 blank mid-scan, segments keep following
        wr_ctl(8'h03);
        for (int k = 0; k < 10; k++) tick_once();
        check("R8 blank com0 non-select", int'(com_at(0) == 1 || com_at(0) == 3), 1);
        wr_ctl(8'h07);
        for (int k = 0; k < 9; k++) tick_once();

        // R9 write mid-slot has no effect until the next tick
        wr_ctl(8'h01);
        tick_once();
        wr_dot(0, 8'hFF);
        check("R9 seg0 before tick", seg_at(0), exp_seg(0));
        tick_once();
        check("R9 seg0 after tick on", int'(seg_at(0) == 0 || seg_at(0) == 4), 1);
        wr_dot(0, 8'h00);
        tick_once();
        check("R9 seg0 after tick off", seg_at(0), 2);

        // R6 alternate type 0 polarity over many slots
        for (int k = 0; k < 20; k++) tick_once();

        // R2 disable grounds all, restart at common 0
        wr_ctl(8'h00);
        check("R2 off com", int'(com_lvl), 0);
        check("R2 off seg", int'(|seg_lvl), 0);
        wr_ctl(8'h01);
        tick_once();
        check("R2 restart com0 selected", com_at(0), 4);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule